// File: doc/BRIEF.md
# Redundant Supply Supervisor with Active-Unit Rotation

This block oversees a group of two or more interchangeable power supply units. Each unit reports three digital lines: whether it is seated, whether its internal health flag is good, and whether its output is in regulation. The block decides which units are enabled, raises an alarm line while any unit is condemned, and publishes a per-unit state code, the active unit index and a handover flag to the main controller.

Two operating styles are selected by a plain mode pin. In hot-standby one unit carries the load while the rest wait. The carrying role is rotated on a programmable interval so that every waiting unit gets exercised. Each rotation is make-before-break: the incoming unit is switched on and must show regulated output before the outgoing one is switched off. In load-sharing every qualified unit is switched on together, so any survivor carries the load when a peer drops out. Units may be pulled and reseated while the supervisor runs. A reseated unit must show a steady health flag for a programmable number of cycles before it can be used, and its admission never disturbs the unit already carrying the load.

All pins are plain control and status levels, with no data stream and no handshake. The outputs are registered and respond one to three clock cycles after an input change.

Top module: `supply_supervisor`

## Requirements
- R1: In hot-standby mode (share_mode=0), outside a handover, at most one unit_en bit is high. When no unit is active, the lowest-index qualified unit is chosen.
- R2: When the active unit in hot-standby is condemned or pulled, the next qualified unit in cyclic index order (index+1, wrapping) is enabled alone within three cycles. If none is qualified, unit_en is all zero.
- R3: In load-sharing mode (share_mode=1), unit_en equals the set of qualified units. A condemned unit is dropped and the survivors stay enabled.
- R4: alarm is high exactly while at least one unit is in the condemned state. A condemned unit stays condemned until its unit_present goes low.
- R5: A qualified unit is condemned when any of these holds: its unit_good is low; its unit_pg falls after having been seen high while enabled; or its unit_pg stays low for SETTLE_TMO cycles after it is enabled.
- R6: In hot-standby with rot_interval non-zero, the active role moves to the next qualified unit in cyclic order about every rot_interval cycles. A rot_interval of zero disables rotation.
- R7: During a rotation both the outgoing and the incoming unit are enabled. The outgoing unit is disabled only after the incoming unit has shown unit_pg high. unit_en never drops to zero because of a rotation.
- R8: If the incoming unit of a rotation is condemned through the settle timeout, the rotation is abandoned, alarm rises, and the outgoing unit stays the only enabled unit.
- R9: Rotation never selects a condemned or unqualified unit. No rotation starts while fewer than two units are qualified.
- R10: A seated unit becomes qualified only after unit_good has been high on dbnc_cycles consecutive cycles (a value of 0 counts as 1). Its admission leaves unit_en unchanged in hot-standby.
- R11: unit_status holds 2 bits per unit, with unit i at bits [2i+1:2i]. The codes are 0 empty, 1 qualifying, 2 qualified, 3 condemned. After reset all codes are 0, unit_en is 0, alarm is 0 and active_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_mode | input | 1 | 0 hot-standby, 1 load-sharing |
| rot_interval | input | ROT_W | Cycles between rotations; 0 disables rotation |
| dbnc_cycles | input | DBNC_W | Consecutive good cycles needed to qualify a seated unit |
| unit_present | input | N_UNITS | Unit seated, one bit per unit |
| unit_good | input | N_UNITS | Unit health flag, one bit per unit |
| unit_pg | input | N_UNITS | Unit output in regulation, one bit per unit |
| unit_en | output | N_UNITS | Unit enable, one bit per unit |
| alarm | output | 1 | High while any unit is condemned |
| active_idx | output | IDX_W | Index of the carrying unit in hot-standby |
| active_vld | output | 1 | active_idx is meaningful |
| handover | output | 1 | A make-before-break rotation is in progress |
| unit_status | output | 2*N_UNITS | Per-unit state codes |

## Verification
The bench goes after a rotation whose incoming unit never regulates. A design without the settle timeout would hang with two units enabled. A design that broke before make would leave the load on a dead unit. It also checks that rotation skips a condemned unit and stays quiet with a single qualified unit. A design that rotated blindly would enable the condemned unit, or would toggle unit_en with nothing to switch to. A bouncing health flag on a reseated unit is used to expose a debounce that does not restart on a low sample. Failover with no qualified unit left, and a mode change from load-sharing back to hot-standby, expose enable sets that keep stale bits.

// File: rtl/supply_sup_pkg.sv
package supply_sup_pkg;

  typedef enum logic [1:0] {
    U_EMPTY   = 2'd0,
    U_QUAL    = 2'd1,
    U_READY   = 2'd2,
    U_FAILED  = 2'd3
  } unit_st_e;

endpackage

// File: rtl/supply_unit_mon.sv
module supply_unit_mon
  import supply_sup_pkg::*;
#(
  parameter int DBNC_W     = 8,
  parameter int SETTLE_TMO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present,
  input  logic              good,
  input  logic              pg,
  input  logic              en,
  input  logic [DBNC_W-1:0] dbnc_cycles,
  output unit_st_e          st,
  output logic              eligible,
  output logic              settled
);

  localparam int TMR_W = $clog2(SETTLE_TMO + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SETTLE_TMO - 1);

  unit_st_e          st_q;
  logic [DBNC_W-1:0] cnt_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              settled_q;
  logic [DBNC_W:0]   need;
  logic              settle_fail;
  logic              pg_drop;

  assign need        = (dbnc_cycles == '0) ? (DBNC_W+1)'(1) : {1'b0, dbnc_cycles};
  assign settle_fail = en && !settled_q && !pg && (tmr_q == TMR_LAST);
  assign pg_drop     = en && settled_q && !pg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= U_EMPTY;
      cnt_q <= '0;
    end else if (!present) begin
      st_q  <= U_EMPTY;
      cnt_q <= '0;
    end else begin
      case (st_q)
        U_EMPTY: begin
          st_q  <= U_QUAL;
          cnt_q <= '0;
        end
        U_QUAL: begin
          if (!good) begin
            cnt_q <= '0;
          end else if (({1'b0, cnt_q} + 1'b1) >= need) begin
            st_q  <= U_READY;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        U_READY: begin
          if (!good || settle_fail || pg_drop) st_q <= U_FAILED;
        end
        default: st_q <= U_FAILED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settled_q <= 1'b0;
      tmr_q     <= '0;
    end else if (!en || st_q != U_READY) begin
      settled_q <= 1'b0;
      tmr_q     <= '0;
    end else if (!settled_q) begin
      if (pg) settled_q <= 1'b1;
      else    tmr_q     <= tmr_q + 1'b1;
    end
  end

  assign st       = st_q;
  assign eligible = (st_q == U_READY);
  assign settled  = settled_q;

  // R10
  dbnc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == U_QUAL && !good) |=> (st_q != U_READY));

  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == U_FAILED && present) |=> (st_q == U_FAILED));

endmodule

// File: rtl/supply_rot_ctrl.sv
module supply_rot_ctrl #(
  parameter int N     = 3,
  parameter int IDX_W = 2,
  parameter int ROT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             share,
  input  logic [ROT_W-1:0] rot_interval,
  input  logic [N-1:0]     elig,
  input  logic [N-1:0]     settled,
  output logic [N-1:0]     en,
  output logic [IDX_W-1:0] act_idx,
  output logic             act_vld,
  output logic             handing
);

  logic [IDX_W-1:0] act_q, act_n, nxt_q, nxt_n;
  logic             vld_q, vld_n, hand_q, hand_n;
  logic [ROT_W-1:0] tmr_q, tmr_n;
  logic [N-1:0]     en_q, en_n;
  logic [IDX_W:0]   pick_fail, pick_rot;
  logic [$clog2(N+1)-1:0] n_elig;

  // Cyclic search: first set bit of mask after index 'from' (from itself last).
  function automatic logic [IDX_W:0] pick_next(input logic [IDX_W-1:0] from,
                                               input logic [N-1:0] mask);
    logic [IDX_W:0] r;
    r = '0;
    for (int k = N; k >= 1; k--) begin
      int j;
      j = (int'(from) + k) % N;
      if (mask[j]) r = {1'b1, IDX_W'(j)};
    end
    return r;
  endfunction

  function automatic logic [N-1:0] onehot(input logic [IDX_W-1:0] i);
    logic [N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  assign n_elig    = $countones(elig);
  assign pick_fail = pick_next(vld_q ? act_q : IDX_W'(N-1), elig);
  assign pick_rot  = pick_next(act_q, elig & ~onehot(act_q));

  always_comb begin
    act_n  = act_q;
    nxt_n  = nxt_q;
    vld_n  = vld_q;
    hand_n = hand_q;
    tmr_n  = tmr_q;
    if (share) begin
      vld_n  = 1'b0;
      hand_n = 1'b0;
      tmr_n  = '0;
    end else if (!vld_q || !elig[act_q]) begin
      tmr_n  = '0;
      hand_n = 1'b0;
      if (vld_q && hand_q && elig[nxt_q]) begin
        act_n = nxt_q;
      end else begin
        vld_n = pick_fail[IDX_W];
        act_n = pick_fail[IDX_W-1:0];
      end
    end else if (hand_q) begin
      if (!elig[nxt_q]) begin
        hand_n = 1'b0;
        tmr_n  = '0;
      end else if (settled[nxt_q]) begin
        act_n  = nxt_q;
        hand_n = 1'b0;
        tmr_n  = '0;
      end
    end else begin
      if (rot_interval == '0 || n_elig < 2) begin
        tmr_n = '0;
      end else if (tmr_q >= rot_interval - 1'b1) begin
        tmr_n  = '0;
        hand_n = pick_rot[IDX_W];
        nxt_n  = pick_rot[IDX_W-1:0];
      end else begin
        tmr_n = tmr_q + 1'b1;
      end
    end

    if (share)      en_n = elig;
    else if (vld_n) en_n = onehot(act_n) | (hand_n ? onehot(nxt_n) : '0);
    else            en_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      nxt_q  <= '0;
      vld_q  <= 1'b0;
      hand_q <= 1'b0;
      tmr_q  <= '0;
      en_q   <= '0;
    end else begin
      act_q  <= act_n;
      nxt_q  <= nxt_n;
      vld_q  <= vld_n;
      hand_q <= hand_n;
      tmr_q  <= tmr_n;
      en_q   <= en_n;
    end
  end

  assign en      = en_q;
  assign act_idx = act_q;
  assign act_vld = vld_q;
  assign handing = hand_q;

  // R1
  hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!share && !$past(share) && !hand_q) |-> ($countones(en_q) <= 1));

  // R7
  mbb_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_q |-> (vld_q && en_q[act_q] && en_q[nxt_q]));

  // R9
  no_rot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!share && !hand_q && n_elig < 2) |=> !hand_q);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supply_sup_pkg::*;
#(
  parameter int N_UNITS    = 3,
  parameter int DBNC_W     = 8,
  parameter int ROT_W      = 16,
  parameter int SETTLE_TMO = 16,
  localparam int IDX_W     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 share_mode,
  input  logic [ROT_W-1:0]     rot_interval,
  input  logic [DBNC_W-1:0]    dbnc_cycles,
  input  logic [N_UNITS-1:0]   unit_present,
  input  logic [N_UNITS-1:0]   unit_good,
  input  logic [N_UNITS-1:0]   unit_pg,
  output logic [N_UNITS-1:0]   unit_en,
  output logic                 alarm,
  output logic [IDX_W-1:0]     active_idx,
  output logic                 active_vld,
  output logic                 handover,
  output logic [2*N_UNITS-1:0] unit_status
);

  logic [N_UNITS-1:0] elig, settled, failed;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    unit_st_e st;
    supply_unit_mon #(.DBNC_W(DBNC_W), .SETTLE_TMO(SETTLE_TMO)) u_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .present     (unit_present[g]),
      .good        (unit_good[g]),
      .pg          (unit_pg[g]),
      .en          (unit_en[g]),
      .dbnc_cycles (dbnc_cycles),
      .st          (st),
      .eligible    (elig[g]),
      .settled     (settled[g])
    );
    assign failed[g]            = (st == U_FAILED);
    assign unit_status[2*g +: 2] = st;
  end

  supply_rot_ctrl #(.N(N_UNITS), .IDX_W(IDX_W), .ROT_W(ROT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .share        (share_mode),
    .rot_interval (rot_interval),
    .elig         (elig),
    .settled      (settled),
    .en           (unit_en),
    .act_idx      (active_idx),
    .act_vld      (active_vld),
    .handing      (handover)
  );

  assign alarm = |failed;

endmodule

// File: tb/sim_supply_supervisor.sv
module sim_supply_supervisor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       share_mode = 1'b0;
  logic [15:0] rot_interval = '0;
  logic [7:0] dbnc_cycles = 8'd4;
  logic [2:0] present = '0, good = '0, dead = '0, pg = '0;
  logic [2:0] en;
  logic       alarm, active_vld, handover;
  logic [1:0] active_idx;
  logic [5:0] status;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  supply_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .share_mode(share_mode), .rot_interval(rot_interval),
    .dbnc_cycles(dbnc_cycles), .unit_present(present), .unit_good(good), .unit_pg(pg),
    .unit_en(en), .alarm(alarm), .active_idx(active_idx), .active_vld(active_vld),
    .handover(handover), .unit_status(status)
  );

  // Supply model: output regulates one cycle after enable unless dead.
  always_ff @(posedge clk) pg <= en & ~dead;

  // {present, good, dead, share, wait[7:0], exp_en, exp_alarm}
  localparam logic [21:0] TBL [13] = '{
    {3'b111, 3'b111, 3'b000, 1'b0, 8'd20, 3'b001, 1'b0},
    {3'b111, 3'b110, 3'b000, 1'b0, 8'd10, 3'b010, 1'b1},
    {3'b110, 3'b110, 3'b000, 1'b0, 8'd10, 3'b010, 1'b0},
    {3'b111, 3'b111, 3'b000, 1'b0, 8'd10, 3'b010, 1'b0},
    {3'b111, 3'b111, 3'b000, 1'b1, 8'd20, 3'b111, 1'b0},
    {3'b111, 3'b111, 3'b100, 1'b1, 8'd10, 3'b011, 1'b1},
    {3'b011, 3'b111, 3'b000, 1'b1, 8'd10, 3'b011, 1'b0},
    {3'b111, 3'b111, 3'b000, 1'b1, 8'd10, 3'b111, 1'b0},
    {3'b111, 3'b111, 3'b000, 1'b0, 8'd10, 3'b001, 1'b0},
    {3'b111, 3'b101, 3'b000, 1'b0, 8'd10, 3'b001, 1'b1},
    {3'b111, 3'b000, 3'b000, 1'b0, 8'd10, 3'b000, 1'b1},
    {3'b000, 3'b111, 3'b000, 1'b0, 8'd10, 3'b000, 1'b0},
    {3'b111, 3'b111, 3'b000, 1'b0, 8'd20, 3'b001, 1'b0}
  };

  function automatic string tag_of(int s);
    case (s)
      0, 8, 12: return "R1";
      1, 10:    return "R2";
      4, 7:     return "R3";
      2, 6, 11: return "R4";
      5, 9:     return "R5";
      default:  return "R10";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(4);
    // R11 reset state
    chk(en == 0, "R11 en", int'(en), 0);
    chk(alarm == 0 && active_vld == 0, "R11 alarm/vld", int'({alarm, active_vld}), 0);
    chk(status == 0, "R11 status", int'(status), 0);
    rst_n = 1'b1;
    step(2);

    for (int s = 0; s < 13; s++) begin
      logic [21:0] v;
      v = TBL[s];
      present = v[21:19]; good = v[18:16]; dead = v[15:13]; share_mode = v[12];
      step(int'(v[11:4]));
      chk(en == v[3:1], tag_of(s), int'(en), int'(v[3:1]));
      chk(alarm == v[0], tag_of(s), int'(alarm), int'(v[0]));
    end

    // R6 / R7: rotation order, overlap, no dark gap
    begin
      int chg = 0, last = int'(active_idx), lastt = 0;
      int seq[3];
      int gap[3];
      bit ovl = 0, dark = 0;
      rot_interval = 16'd30;
      for (int c = 0; c < 300 && chg < 3; c++) begin
        @(negedge clk);
        if (en == 0) dark = 1;
        if ($countones(en) == 2) ovl = 1;
        if (int'(active_idx) != last) begin
          seq[chg] = int'(active_idx); gap[chg] = c - lastt;
          lastt = c; chg++; last = int'(active_idx);
        end
      end
      chk(chg == 3, "R6 rotations seen", chg, 3);
      chk(seq[0] == 1 && seq[1] == 2 && seq[2] == 0, "R6 order", seq[0]*100 + seq[1]*10 + seq[2], 120);
      chk(gap[1] >= 30 && gap[1] <= 40, "R6 interval", gap[1], 33);
      chk(ovl, "R7 overlap", int'(ovl), 1);
      chk(!dark, "R7 never dark", int'(dark), 0);
    end

    // R9: rotation skips a condemned unit
    begin
      int chg = 0, last;
      bit hit1 = 0;
      good = 3'b101;
      step(3);
      last = int'(active_idx);
      for (int c = 0; c < 250; c++) begin
        @(negedge clk);
        if (en[1] || active_idx == 1) hit1 = 1;
        if (int'(active_idx) != last) begin chg++; last = int'(active_idx); end
      end
      chk(!hit1, "R9 skip condemned", int'(hit1), 0);
      chk(chg >= 2, "R9 rotation continues", chg, 2);
      chk(alarm == 1, "R4 alarm held", int'(alarm), 1);
    end

    // R9: suppression with a single qualified unit
    begin
      bit moved = 0;
      present = 3'b011;
      step(10);
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        if (handover || en != 3'b001) moved = 1;
      end
      chk(!moved, "R9 suppressed", int'(en), 1);
    end

    // R8: incoming unit never regulates
    begin
      bit seen = 0;
      present = 3'b000; step(3);
      good = 3'b111; present = 3'b111; dead = 3'b010;
      for (int c = 0; c < 300 && !seen; c++) begin
        @(negedge clk);
        if (alarm) seen = 1;
      end
      chk(seen, "R8 alarm on timeout", int'(seen), 1);
      chk(active_idx == 0, "R8 outgoing kept", int'(active_idx), 0);
      chk(status[3:2] == 2'd3, "R8 incoming condemned", int'(status[3:2]), 3);
      step(3);
      chk(en == 3'b001, "R8 abort", int'(en), 1);
      seen = 0;
      for (int c = 0; c < 200 && !seen; c++) begin
        @(negedge clk);
        if (active_idx == 2 && en == 3'b100) seen = 1;
      end
      chk(seen, "R9 next after condemned", int'(active_idx), 2);
    end

    // R10: debounce of a reseated unit with a bouncing health flag
    begin
      logic [2:0] en0;
      rot_interval = '0; dead = '0;
      present = 3'b101; step(3);
      en0 = en;
      present = 3'b111;
      for (int k = 0; k < 12; k++) begin
        good[1] = (k % 3 != 2);
        step(1);
      end
      chk(status[3:2] == 2'd1, "R10 bounce holds off", int'(status[3:2]), 1);
      good[1] = 1'b1;
      step(2);
      chk(status[3:2] == 2'd1, "R10 still qualifying", int'(status[3:2]), 1);
      step(4);
      chk(status[3:2] == 2'd2, "R10 qualified", int'(status[3:2]), 2);
      chk(en == en0, "R10 load undisturbed", int'(en), int'(en0));
      chk(status == 6'b101010, "R11 codes", int'(status), 42);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule